// File: doc/BRIEF.md
# Sequential Unsigned 32/16 Divider

This block divides a 32-bit unsigned dividend by a 16-bit unsigned divisor, one quotient bit per clock. The dividend arrives as two 16-bit halves, an upper word and a lower word. When the quotient fits in 16 bits, the quotient comes back on the lower result word and the remainder on the upper result word. When it does not fit, the block raises an overflow flag and returns all ones in both result words.

Overflow is decided before any subtraction takes place, by one unsigned comparison of the divisor against the upper dividend word. The decision is exact for every operand pair, including pairs where the most significant bits of both the upper word and the divisor are set. A zero divisor is always caught by the same comparison. A caller pulses `start` with the operands, watches `busy`, and reads the results in the cycle in which `done` pulses. The results stay on the outputs until the next operation completes.

The controller has four states. IDLE waits for work. SETUP holds the captured operands and evaluates overflow. RUN performs the shift-subtract steps. DONE presents the results for one cycle. The transitions are:
- start-accept (IDLE or DONE to SETUP, when `start` is high)
- overflow-exit (SETUP to DONE)
- begin-run (SETUP to RUN)
- step-loop (RUN to RUN, while steps remain)
- last-step (RUN to DONE)
- retire (DONE to IDLE, when `start` is low)

Top module: `udiv_long`

## Requirements
- R1: After reset, `busy`, `done` and `ovf` are 0, and `hi_out` and `lo_out` are 0.
- R2: A start is accepted only when `start` is 1 at a rising edge while `busy` is 0. The dividend is {`hi_in`,`lo_in`} (upper word first) and the divisor is `dvsr_in`, all sampled at that edge.
- R3: `ovf` is 1 exactly when the divisor is less than or equal to `hi_in`. This holds when the top bits of both are set: F0F0_0F0Fh / F0F0h gives `ovf`=1.
- R4: When `ovf` is 0, `lo_out` equals the 16-bit quotient and `hi_out` equals the remainder of the dividend divided by the divisor.
- R5: When `ovf` is 1, both `lo_out` and `hi_out` read FFFFh.
- R6: A zero divisor gives `ovf`=1, with both result words FFFFh.
- R7: Without overflow, `busy` is 1 for the 17 cycles that follow the accepting edge (1 setup cycle and 16 step cycles), and `done` is 1 in the 18th cycle. With overflow, `busy` is 1 for one cycle and `done` is 1 in the 2nd cycle.
- R8: `done` is a single-cycle pulse, and `busy` is 0 whenever `done` is 1. The results and `ovf` hold their values until the next operation completes.
- R9: A `start` pulse while `busy` is 1 is ignored. The running operation's results and latency are unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request to begin a division |
| hi_in | input | 16 | Upper word of the dividend |
| lo_in | input | 16 | Lower word of the dividend |
| dvsr_in | input | 16 | Divisor |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse; results are valid |
| hi_out | output | 16 | Remainder, or FFFFh on overflow |
| lo_out | output | 16 | Quotient, or FFFFh on overflow |
| ovf | output | 1 | Quotient does not fit in 16 bits |

## Verification
A result is due 18 cycles after the accepting edge without overflow, and 2 cycles after it with overflow.

The bench drives inputs on falling edges and counts falling edges from the accepting edge until `done` appears. It checks that this count matches the latency predicted from the overflow comparison, then compares `ovf` and both result words with values it computes itself. One falling edge later it checks that `done` has dropped and that the results have held.

In some runs a stray `start` is injected mid-run with different operands. For those runs the same latency and results must still appear.

// File: rtl/udiv_pkg.sv
package udiv_pkg;

    localparam int unsigned DEF_W = 16;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SETUP = 2'd1,
        ST_RUN   = 2'd2,
        ST_DONE  = 2'd3
    } udiv_state_e;

endpackage

// File: rtl/udiv_ovf_detect.sv
module udiv_ovf_detect #(
    parameter int unsigned W = udiv_pkg::DEF_W
) (
    input  logic [W-1:0] upper,
    input  logic [W-1:0] divisor,
    output logic         too_big
);
    // Full-width unsigned compare; a zero divisor always satisfies it.
    always_comb begin
        too_big = (divisor <= upper);
    end
endmodule

// File: rtl/udiv_ctrl.sv
module udiv_ctrl
    import udiv_pkg::*;
#(
    parameter int unsigned W = DEF_W
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic ovf_hit,
    output logic busy,
    output logic done,
    output logic load_ops,
    output logic step_en,
    output logic fin_ovf,
    output logic fin_div
);
    localparam int unsigned CW = (W > 1) ? $clog2(W) : 1;
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    udiv_state_e state_q, state_d;
    logic [CW-1:0] cnt_q;
    logic          last_step;

    assign last_step = (cnt_q == LAST);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start) state_d = ST_SETUP;
            ST_SETUP: state_d = ovf_hit ? ST_DONE : ST_RUN;
            ST_RUN:   if (last_step) state_d = ST_DONE;
            ST_DONE:  state_d = start ? ST_SETUP : ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 cnt_q <= '0;
        else if (state_q != ST_RUN) cnt_q <= '0;
        else                        cnt_q <= cnt_q + 1'b1;
    end

    always_comb begin
        busy     = 1'b0;
        done     = 1'b0;
        load_ops = 1'b0;
        step_en  = 1'b0;
        fin_ovf  = 1'b0;
        fin_div  = 1'b0;
        unique case (state_q)
            ST_IDLE:  load_ops = start;
            ST_SETUP: begin
                busy    = 1'b1;
                fin_ovf = ovf_hit;
            end
            ST_RUN: begin
                busy    = 1'b1;
                step_en = 1'b1;
                fin_div = last_step;
            end
            ST_DONE: begin
                done     = 1'b1;
                load_ops = start;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/udiv_core.sv
module udiv_core #(
    parameter int unsigned W = udiv_pkg::DEF_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_ops,
    input  logic         step_en,
    input  logic         fin_ovf,
    input  logic         fin_div,
    input  logic [W-1:0] hi_in,
    input  logic [W-1:0] lo_in,
    input  logic [W-1:0] dvsr_in,
    output logic [W-1:0] cur_hi,
    output logic [W-1:0] cur_dv,
    output logic [W-1:0] res_hi,
    output logic [W-1:0] res_lo,
    output logic         res_ovf
);
    logic [W-1:0] rem_q, quo_q, dv_q;
    logic [W:0]   shl, diff;
    logic         ge;
    logic [W-1:0] rem_n, quo_n;

    // One restoring step: shift in the next dividend bit, subtract if it fits.
    always_comb begin
        shl   = {rem_q, quo_q[W-1]};
        diff  = shl - {1'b0, dv_q};
        ge    = (shl >= {1'b0, dv_q});
        rem_n = ge ? diff[W-1:0] : shl[W-1:0];
        quo_n = {quo_q[W-2:0], ge};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q <= '0;
            quo_q <= '0;
            dv_q  <= '0;
        end else if (load_ops) begin
            rem_q <= hi_in;
            quo_q <= lo_in;
            dv_q  <= dvsr_in;
        end else if (step_en) begin
            rem_q <= rem_n;
            quo_q <= quo_n;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_hi  <= '0;
            res_lo  <= '0;
            res_ovf <= 1'b0;
        end else if (fin_ovf) begin
            res_hi  <= '1;
            res_lo  <= '1;
            res_ovf <= 1'b1;
        end else if (fin_div) begin
            res_hi  <= rem_n;
            res_lo  <= quo_n;
            res_ovf <= 1'b0;
        end
    end

    assign cur_hi = rem_q;
    assign cur_dv = dv_q;
endmodule

// File: rtl/udiv_long.sv
module udiv_long #(
    parameter int unsigned W = udiv_pkg::DEF_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] hi_in,
    input  logic [W-1:0] lo_in,
    input  logic [W-1:0] dvsr_in,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] hi_out,
    output logic [W-1:0] lo_out,
    output logic         ovf
);
    logic         load_ops, step_en, fin_ovf, fin_div, ovf_hit;
    logic [W-1:0] cur_hi, cur_dv;

    udiv_ctrl #(.W(W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .ovf_hit  (ovf_hit),
        .busy     (busy),
        .done     (done),
        .load_ops (load_ops),
        .step_en  (step_en),
        .fin_ovf  (fin_ovf),
        .fin_div  (fin_div)
    );

    udiv_ovf_detect #(.W(W)) u_ovf (
        .upper   (cur_hi),
        .divisor (cur_dv),
        .too_big (ovf_hit)
    );

    udiv_core #(.W(W)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_ops (load_ops),
        .step_en  (step_en),
        .fin_ovf  (fin_ovf),
        .fin_div  (fin_div),
        .hi_in    (hi_in),
        .lo_in    (lo_in),
        .dvsr_in  (dvsr_in),
        .cur_hi   (cur_hi),
        .cur_dv   (cur_dv),
        .res_hi   (hi_out),
        .res_lo   (lo_out),
        .res_ovf  (ovf)
    );
endmodule

// File: rtl/udiv_long_chk.sv
module udiv_long_chk #(
    parameter int unsigned W = udiv_pkg::DEF_W
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic [W-1:0] hi_in,
    input logic [W-1:0] lo_in,
    input logic [W-1:0] dvsr_in,
    input logic         busy,
    input logic         done,
    input logic [W-1:0] hi_out,
    input logic [W-1:0] lo_out,
    input logic         ovf
);
    logic [W-1:0]   cap_hi, cap_lo, cap_dv;
    logic [2*W-1:0] recon, dvdnd;
    logic [7:0]     busy_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_hi <= '0;
            cap_lo <= '0;
            cap_dv <= '0;
        end else if (start && !busy) begin
            cap_hi <= hi_in;
            cap_lo <= lo_in;
            cap_dv <= dvsr_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    busy_len <= '0;
        else if (busy) busy_len <= busy_len + 8'd1;
        else           busy_len <= '0;
    end

    always_comb begin
        recon = ({{W{1'b0}}, lo_out} * {{W{1'b0}}, cap_dv}) + {{W{1'b0}}, hi_out};
        dvdnd = {cap_hi, cap_lo};
    end

    // R3
    ovf_rule_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (ovf == (cap_dv <= cap_hi)));

    // R4
    quot_rem_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !ovf) |-> ((recon == dvdnd) && (hi_out < cap_dv)));

    // R5
    ovf_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && ovf) |-> ((lo_out == '1) && (hi_out == '1)));

    // R7
    busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_len <= 8'(W + 1));

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    done_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R8
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!done && $past(!done)) |-> ($stable(lo_out) && $stable(hi_out) && $stable(ovf)));
endmodule

bind udiv_long udiv_long_chk #(.W(W)) u_chk (.*);

// File: tb/udiv_long_tb.sv
module udiv_long_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] hi_in = '0, lo_in = '0, dvsr_in = '0;
    logic        busy, done, ovf;
    logic [15:0] hi_out, lo_out;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    udiv_long u_dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .hi_in(hi_in), .lo_in(lo_in), .dvsr_in(dvsr_in),
        .busy(busy), .done(done), .hi_out(hi_out), .lo_out(lo_out), .ovf(ovf)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic bit exp_ovf(input logic [15:0] h, input logic [15:0] d);
        return d <= h;
    endfunction

    function automatic logic [31:0] exp_res(input logic [15:0] h, input logic [15:0] l, input logic [15:0] d);
        logic [31:0] dd;
        logic [31:0] q, r;
        if (d <= h) return 32'hFFFF_FFFF;
        dd = {h, l};
        q = dd / {16'd0, d};
        r = dd % {16'd0, d};
        return {r[15:0], q[15:0]};
    endfunction

    task automatic run_op(input logic [15:0] h, input logic [15:0] l, input logic [15:0] d, input bit poke);
        int n;
        bit eo;
        logic [31:0] er;
        eo = exp_ovf(h, d);
        er = exp_res(h, l, d);
        @(negedge clk);
        hi_in = h; lo_in = l; dvsr_in = d; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n = 1;
        chk(busy == 1'b1, "R2 busy after accept", {31'd0, busy}, 32'd1);
        while (!done && n < 60) begin
            if (poke && n == 4) begin
                start = 1'b1; hi_in = ~h; lo_in = ~l; dvsr_in = d ^ 16'h5A5A; // R9
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            n++;
        end
        start = 1'b0;
        chk(n == (eo ? 2 : 18), poke ? "R9 latency with stray start" : "R7 latency", n, eo ? 2 : 18);
        chk(ovf == eo, (d == 0) ? "R6 zero divisor flag" : "R3 overflow flag", {31'd0, ovf}, {31'd0, eo});
        chk({hi_out, lo_out} == er, eo ? "R5 overflow results" : (poke ? "R9 results" : "R4 quotient/remainder"),
            {hi_out, lo_out}, er);
        chk(busy == 1'b0, "R8 busy low with done", {31'd0, busy}, 32'd0);
        @(negedge clk);
        chk(done == 1'b0 && {hi_out, lo_out} == er && ovf == eo, "R8 pulse and hold",
            {done, 15'd0, lo_out}, {1'b0, 15'd0, er[15:0]});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [15:0] h, l, d;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(busy == 0 && done == 0 && ovf == 0, "R1 reset flags", {busy, done, ovf}, 0);
        chk(hi_out == 0 && lo_out == 0, "R1 reset results", {hi_out, lo_out}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R3 directed corner cases
        run_op(16'hF0F0, 16'h0F0F, 16'hF0F0, 1'b0);
        run_op(16'h8000, 16'h0000, 16'h8000, 1'b0);
        run_op(16'hFFFF, 16'hFFFF, 16'hFFFF, 1'b0);
        run_op(16'h8001, 16'h0000, 16'h8000, 1'b0);
        run_op(16'hFFFE, 16'hFFFF, 16'hFFFF, 1'b0);
        run_op(16'h7FFF, 16'hFFFF, 16'h8000, 1'b0);
        run_op(16'h0000, 16'h1234, 16'h0001, 1'b0);
        run_op(16'h0000, 16'h0000, 16'h0000, 1'b0); // R6
        run_op(16'h1234, 16'h5678, 16'h0000, 1'b0); // R6
        run_op(16'h0000, 16'hFFFF, 16'h0001, 1'b1); // R9
        run_op(16'h1000, 16'h0000, 16'h2000, 1'b1);
        for (int i = 0; i < 300; i++) begin
            d = 16'($urandom);
            l = 16'($urandom);
            case (i % 4)
                0: h = (d == 0) ? 16'd0 : 16'($urandom % {16'd0, d});
                1: h = 16'($urandom);
                2: begin d[15] = 1'b1; h = 16'($urandom) | 16'h8000; end
                default: begin h = d - 16'($urandom % 3); end
            endcase
            run_op(h, l, d, (i % 7) == 3);
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule